// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block is a non-blocking crosspoint router with N_IN data inputs and N_OUT data outputs (eight of each by default). Every output has its own registered selector, so each output picks any input on its own, and one input can feed any number of outputs at once. Each output also has an enable. A disabled output drops its output-enable flag and drives all-zero data, which stands in for a high-impedance pad.

The routing state is held twice. A host writes one output's route and enable per cycle into a pending (shadow) bank, and traffic keeps flowing on the routes in the live (active) bank. A single-cycle configure strobe copies the whole pending bank into the live bank, so every route changes in the same cycle. Outputs whose settings do not change keep streaming with no gap. Two synchronous reset inputs load both banks: one routes every output to input 0 with all outputs enabled, and the other disables every output.

Top module: `xpt_switch`

## Requirements
- R1: An enabled output presents, one clock after each rising edge, the data word that its routed input held at that edge. The output data and output-enable are both registered.
- R2: A single input may be routed to every output at the same time, and each of those outputs carries that input's data.
- R3: An output whose live enable is 0 drives oe low and dout all zeros. This holds whatever data its selected input carries.
- R4: A write (wr_en high with cfg low) changes only the pending bank. The live routes, and therefore dout and oe, are unaffected until a configure strobe.
- R5: A configure strobe at edge k copies the whole pending bank into the live bank. All changed outputs switch together, and they carry data sampled at edge k+1 on their new routes.
- R6: An output whose route and enable are the same before and after a configure strobe carries correct data on every cycle around that strobe.
- R7: When a write and a configure strobe occur in the same cycle, the live bank receives the pending bank with that write already applied.
- R8: With rst_bcast high and rst_off low at an edge, both banks are set to input 0 with enable 1 for every output. A later configure strobe with no write in between keeps that routing.
- R9: With rst_off high at an edge, both banks are set with every output disabled. Select fields are cleared to 0.
- R10: When both reset inputs are high, the disable-all reset takes effect.
- R11: Resets take priority over writes and configure strobes. A write or strobe during a reset cycle leaves no trace in either bank.
- R12: A write updates only the entry addressed by wr_out, setting its select to wr_sel and its enable to wr_on. All other entries stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_bcast | input | 1 | Synchronous reset that routes all outputs to input 0, enabled |
| rst_off | input | 1 | Synchronous reset that disables all outputs; wins over rst_bcast |
| wr_en | input | 1 | Write strobe for the pending bank |
| wr_out | input | $clog2(N_OUT) (3) | Output index being written |
| wr_sel | input | $clog2(N_IN) (3) | Input index to route to that output |
| wr_on | input | 1 | Enable value for that output |
| cfg | input | 1 | Configure strobe: pending bank to live bank |
| din | input | N_IN*DW (32) | Input lanes, lane i at bits [i*DW +: DW] |
| dout | output | N_OUT*DW (32) | Output lanes, lane j at bits [j*DW +: DW] |
| oe | output | N_OUT (8) | Per-output enable, bit j for output j |

## Verification
Each output is due exactly one edge after the data it carries was sampled. A configure strobe at edge k is first visible in the data registered at edge k+1, so a route or enable change appears at the sampling point two edges after the strobe was driven. The bench keeps a model of both banks and computes each cycle's expected dout and oe from the live model as it stood before the edge, together with the din held during that cycle. It drives inputs and samples outputs on falling edges. Resets follow the same rule, so checks start one cycle after the first reset.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [1:0] {
    RST_NONE  = 2'd0,
    RST_BCAST = 2'd1,
    RST_OFF   = 2'd2
  } rst_cmd_e;

  function automatic rst_cmd_e rst_decode(input logic bcast, input logic off);
    if (off)        return RST_OFF;
    else if (bcast) return RST_BCAST;
    else            return RST_NONE;
  endfunction

endpackage

// File: rtl/xpt_bank.sv
module xpt_bank
  import xpt_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  localparam int SW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int AW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                clk,
  input  logic                rst_bcast,
  input  logic                rst_off,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_out,
  input  logic [SW-1:0]       wr_sel,
  input  logic                wr_on,
  input  logic                cfg,
  output logic [N_OUT*SW-1:0] act_sel,
  output logic [N_OUT-1:0]    act_en
);

  logic [N_OUT*SW-1:0] shd_sel, shd_sel_nxt;
  logic [N_OUT-1:0]    shd_en, shd_en_nxt;
  rst_cmd_e            rcmd;

  assign rcmd = rst_decode(rst_bcast, rst_off);

  // pending bank with this cycle's write merged in
  always_comb begin
    shd_sel_nxt = shd_sel;
    shd_en_nxt  = shd_en;
    if (wr_en && (int'(wr_out) < N_OUT)) begin
      shd_sel_nxt[wr_out*SW +: SW] = wr_sel;
      shd_en_nxt[wr_out]           = wr_on;
    end
  end

  always_ff @(posedge clk) begin
    case (rcmd)
      RST_OFF: begin
        shd_sel <= '0;
        shd_en  <= '0;
        act_sel <= '0;
        act_en  <= '0;
      end
      RST_BCAST: begin
        shd_sel <= '0;
        shd_en  <= '1;
        act_sel <= '0;
        act_en  <= '1;
      end
      default: begin
        shd_sel <= shd_sel_nxt;
        shd_en  <= shd_en_nxt;
        if (cfg) begin
          act_sel <= shd_sel_nxt;
          act_en  <= shd_en_nxt;
        end
      end
    endcase
  end

  AST_WR_SHADOW_ONLY: assert property (@(posedge clk) disable iff (rst_bcast || rst_off)
    !cfg |=> ($stable(act_sel) && $stable(act_en))); // R4

  AST_CFG_ALL: assert property (@(posedge clk) disable iff (rst_bcast || rst_off)
    cfg |=> ((act_sel == shd_sel) && (act_en == shd_en))); // R5

  AST_BCAST_STATE: assert property (@(posedge clk) disable iff (rst_off)
    rst_bcast |=> ((act_sel == '0) && (act_en == '1) && (shd_sel == '0) && (shd_en == '1))); // R8

  AST_OFF_STATE: assert property (@(posedge clk)
    rst_off |=> ((act_en == '0) && (shd_en == '0) && (act_sel == '0))); // R10

endmodule

// File: rtl/xpt_lane.sv
module xpt_lane #(
  parameter int N_IN = 8,
  parameter int DW   = 4,
  localparam int SW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic               clk,
  input  logic               rst_any,
  input  logic [N_IN*DW-1:0] din,
  input  logic [SW-1:0]      sel,
  input  logic               en,
  output logic [DW-1:0]      dout,
  output logic               oe
);

  logic [DW-1:0] lanes [N_IN];
  logic [DW-1:0] pick;

  for (genvar i = 0; i < N_IN; i++) begin : g_split
    assign lanes[i] = din[i*DW +: DW];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (int'(sel) == i) pick = lanes[i];
    end
  end

  always_ff @(posedge clk) begin
    oe   <= en;
    dout <= en ? pick : '0;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst_any)
    !oe |-> (dout == '0)); // R3

endmodule

// File: rtl/xpt_switch.sv
module xpt_switch #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int DW    = 4,
  localparam int SW   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int AW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                clk,
  input  logic                rst_bcast,
  input  logic                rst_off,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_out,
  input  logic [SW-1:0]       wr_sel,
  input  logic                wr_on,
  input  logic                cfg,
  input  logic [N_IN*DW-1:0]  din,
  output logic [N_OUT*DW-1:0] dout,
  output logic [N_OUT-1:0]    oe
);

  logic [N_OUT*SW-1:0] act_sel;
  logic [N_OUT-1:0]    act_en;
  logic                rst_any;

  assign rst_any = rst_bcast | rst_off;

  xpt_bank #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bank (
    .clk       (clk),
    .rst_bcast (rst_bcast),
    .rst_off   (rst_off),
    .wr_en     (wr_en),
    .wr_out    (wr_out),
    .wr_sel    (wr_sel),
    .wr_on     (wr_on),
    .cfg       (cfg),
    .act_sel   (act_sel),
    .act_en    (act_en)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    xpt_lane #(.N_IN(N_IN), .DW(DW)) u_lane (
      .clk     (clk),
      .rst_any (rst_any),
      .din     (din),
      .sel     (act_sel[j*SW +: SW]),
      .en      (act_en[j]),
      .dout    (dout[j*DW +: DW]),
      .oe      (oe[j])
    );
  end

endmodule

// File: tb/xpt_switch_bench.sv
`timescale 1ns/1ps
module xpt_switch_bench;

  localparam int N_IN  = 8;
  localparam int N_OUT = 8;
  localparam int DW    = 4;
  localparam int SW    = 3;
  localparam int AW    = 3;

  logic                clk = 1'b0;
  logic                rst_bcast, rst_off, wr_en, wr_on, cfg;
  logic [AW-1:0]       wr_out;
  logic [SW-1:0]       wr_sel;
  logic [N_IN*DW-1:0]  din;
  logic [N_OUT*DW-1:0] dout;
  logic [N_OUT-1:0]    oe;

  int checks = 0;
  int errors = 0;

  logic [SW-1:0] m_shd_sel [N_OUT];
  logic          m_shd_en  [N_OUT];
  logic [SW-1:0] m_act_sel [N_OUT];
  logic          m_act_en  [N_OUT];
  bit            valid = 0;

  always #10 clk = ~clk;

  xpt_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_xpt_switch (
    .clk(clk), .rst_bcast(rst_bcast), .rst_off(rst_off), .wr_en(wr_en),
    .wr_out(wr_out), .wr_sel(wr_sel), .wr_on(wr_on), .cfg(cfg),
    .din(din), .dout(dout), .oe(oe)
  );

  function automatic logic [N_IN*DW-1:0] pat(input int seed);
    logic [N_IN*DW-1:0] v;
    for (int i = 0; i < N_IN; i++) v[i*DW +: DW] = 4'((seed * 5 + i * 3 + 1) % 16);
    return v;
  endfunction

  // one clock: drive, predict, advance model, check at next falling edge
  task automatic step(input logic [N_IN*DW-1:0] d, input logic rb, input logic ro,
                      input logic we, input int wo, input int ws, input logic won,
                      input logic cf, input string tag);
    logic [N_OUT*DW-1:0] exp_d;
    logic [N_OUT-1:0]    exp_oe;
    bit                  do_chk;
    din = d; rst_bcast = rb; rst_off = ro; wr_en = we;
    wr_out = AW'(wo); wr_sel = SW'(ws); wr_on = won; cfg = cf;
    do_chk = valid;
    for (int j = 0; j < N_OUT; j++) begin
      exp_oe[j] = m_act_en[j];
      exp_d[j*DW +: DW] = m_act_en[j] ? d[m_act_sel[j]*DW +: DW] : '0;
    end
    if (ro || rb) begin
      for (int j = 0; j < N_OUT; j++) begin
        m_shd_sel[j] = '0; m_act_sel[j] = '0;
        m_shd_en[j] = !ro; m_act_en[j] = !ro;
      end
      valid = 1;
    end else begin
      if (we) begin m_shd_sel[wo] = SW'(ws); m_shd_en[wo] = won; end
      if (cf) for (int j = 0; j < N_OUT; j++) begin
        m_act_sel[j] = m_shd_sel[j]; m_act_en[j] = m_shd_en[j];
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (do_chk) begin
      checks++;
      if (dout !== exp_d || oe !== exp_oe) begin
        errors++;
        $display("FAIL %s: dout=%h oe=%b expected dout=%h oe=%b", tag, dout, oe, exp_d, exp_oe);
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(pat(k + 7), 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int o, input int s, input logic on, input string tag);
    step(pat(o + s), 0, 0, 1, o, s, on, 0, tag);
  endtask

  task automatic t_bcast_reset();
    step(pat(1), 1, 0, 0, 0, 0, 0, 0, "R8 reset");
    idle(3, "R8 broadcast on input 0");
    step(pat(2), 0, 0, 0, 0, 0, 0, 1, "R8 cfg after reset");
    idle(2, "R8 routing kept after cfg");
  endtask

  task automatic t_routes();
    for (int o = 0; o < N_OUT; o++) wr(o, N_IN - 1 - o, 1, "R4 shadow write keeps live");
    idle(1, "R4 live unchanged");
    step(pat(3), 0, 0, 0, 0, 0, 0, 1, "R5 cfg strobe");
    idle(4, "R1 R5 new routes, one-cycle latency");
  endtask

  task automatic t_fanout();
    for (int o = 0; o < N_OUT; o++) wr(o, 5, 1, "R4 write");
    step(pat(4), 0, 0, 0, 0, 0, 0, 1, "R2 cfg");
    idle(3, "R2 input 5 to all outputs");
  endtask

  task automatic t_disable_single();
    wr(3, 2, 0, "R12 write one entry");
    step(pat(5), 0, 0, 0, 0, 0, 0, 1, "R12 cfg");
    idle(3, "R3 R12 out3 off, others unchanged");
  endtask

  task automatic t_stream_across_cfg();
    wr(6, 1, 1, "R6 write out6");
    for (int k = 0; k < 4; k++) step(pat(20 + k), 0, 0, 0, 0, 0, 0, (k == 1), "R6 unchanged outputs stream");
  endtask

  task automatic t_write_with_cfg();
    step(pat(9), 0, 0, 1, 0, 4, 1, 1, "R7 write+cfg same cycle");
    idle(2, "R7 updated entry live");
  endtask

  task automatic t_off_reset();
    step(pat(11), 0, 1, 0, 0, 0, 0, 0, "R9 off reset");
    idle(2, "R9 all disabled");
    step(pat(12), 0, 0, 0, 0, 0, 0, 1, "R9 cfg keeps disabled");
    idle(2, "R3 R9 outputs zero");
  endtask

  task automatic t_both_resets();
    step(pat(13), 1, 0, 0, 0, 0, 0, 0, "R10 bcast first");
    idle(1, "R10 bcast live");
    step(pat(14), 1, 1, 0, 0, 0, 0, 0, "R10 both resets");
    idle(2, "R10 off wins");
  endtask

  task automatic t_reset_priority();
    step(pat(15), 1, 0, 1, 2, 7, 0, 1, "R11 write+cfg during reset");
    idle(1, "R11 reset state");
    step(pat(16), 0, 0, 0, 0, 0, 0, 1, "R11 cfg after reset");
    idle(2, "R11 no trace of ignored write");
  endtask

  initial begin
    #4_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    din = '0; rst_bcast = 1'b1; rst_off = 1'b0; wr_en = 1'b0;
    wr_out = '0; wr_sel = '0; wr_on = 1'b0; cfg = 1'b0;
    for (int j = 0; j < N_OUT; j++) begin
      m_shd_sel[j] = '0; m_shd_en[j] = 0; m_act_sel[j] = '0; m_act_en[j] = 0;
    end
    @(negedge clk);
    t_bcast_reset();
    t_routes();
    t_fanout();
    t_disable_single();
    t_stream_across_cfg();
    t_write_with_cfg();
    t_off_reset();
    t_both_resets();
    t_reset_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule